// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This block builds a 512-bit result vector by replicating either one source element or a short repeating group ("tuple") of source elements across every lane of an active vector length of 128, 256 or 512 bits. Elements are 8, 16, 32 or 64 bits wide, so the lane count is the active length divided by the element width.

A per-lane writemask then decides, lane by lane, whether the lane takes the broadcast value, keeps the value of an old destination vector presented alongside the operation (merge), or is cleared (zero). Masking can be switched off, in which case every active lane is written. Everything at or above the active length is cleared. A one-cycle start strobe launches the operation. The result is registered and a done strobe marks it one cycle later. The result then holds until the next start.

Top module: `vbcast_unit`

## Requirements
- R1: After reset the result is all zeros and the done strobe is low.
- R2: The done strobe is high for exactly the one cycle after a cycle with start high. The result changes only on the edge that follows a start cycle, and it holds its value otherwise.
- R3: The element size code 0, 1, 2, 3 selects 8, 16, 32, 64-bit elements. The length code 0, 1, 2 selects 128, 256, 512 active bits, and code 3 behaves as 512. The lane count is the active bits divided by the element width.
- R4: With tuple code 0, every written lane receives source element 0, which is the lowest element of the source at the chosen width.
- R5: Tuple codes 1, 2, 3 give a group size T of 2, 4, 8. Written lane j receives source element (j mod T). Source bits above 255 read as zero.
- R6: With masking disabled (mask-enable low), every active lane is written, whatever the mask value.
- R7: With masking enabled and merge selected (merge high), an active lane whose mask bit is clear keeps the old destination value of that lane.
- R8: With masking enabled and zeroing selected (merge low), an active lane whose mask bit is clear becomes zero.
- R9: Every result bit from the active length up to bit 511 is zero, whatever the old destination and the mask.
- R10: Lane j uses mask bit j. Mask bits at positions equal to or above the lane count have no effect on the result.
- R11: With 32-bit elements, T=4, a 256-bit length and masking off, the result holds source bits 127:0 in both 128-bit halves of its low 256 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches one broadcast operation |
| src_i | input | 256 | Source vector; element 0 is in the low bits |
| old_i | input | 512 | Old destination vector, used for merged lanes |
| mask_i | input | 64 | Per-lane writemask, bit j for lane j |
| esize_i | input | 2 | Element size code (0=8, 1=16, 2=32, 3=64 bits) |
| tuple_i | input | 2 | Tuple code (0=single, 1=2, 2=4, 3=8 elements) |
| vlen_i | input | 2 | Active length code (0=128, 1=256, 2 or 3=512) |
| mask_en_i | input | 1 | Masking enable |
| merge_i | input | 1 | 1 = merge unselected lanes, 0 = zero them |
| result_o | output | 512 | Registered result vector |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench runs through every combination of element size, tuple code, length code, mask enable and merge select. Each combination uses random source, old destination and mask patterns, and the expected vector is computed element by element in arithmetic. Separate tuple codes tell a wrong modulo apart from a plain broadcast. An all-ones old destination against zeroing tells merge from zero. An all-ones old destination at the shortest length exposes any leak above the active length. Directed cases set mask bits only above the lane count, clear the mask while masking is off, and check the block-copy layout and the strobe and hold timing around start.

// File: rtl/vbcast_pkg.sv
package vbcast_pkg;

    localparam int VEC_W  = 512;
    localparam int SRC_W  = 256;
    localparam int MASK_W = 64;
    localparam int BYTES  = VEC_W / 8;
    localparam int SRC_BYTES = SRC_W / 8;
    localparam int BIDX_W = $clog2(BYTES);

    typedef enum logic [1:0] {
        ES_8  = 2'd0,
        ES_16 = 2'd1,
        ES_32 = 2'd2,
        ES_64 = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_ALT = 2'd3
    } vlen_e;

    typedef struct packed {
        logic [VEC_W-1:0] result;
        logic             done;
    } vb_state_t;

endpackage

// File: rtl/vbcast_replicate.sv
module vbcast_replicate
    import vbcast_pkg::*;
(
    input  logic [SRC_W-1:0] src_i,
    input  logic [1:0]       esize_i,
    input  logic [1:0]       tuple_i,
    output logic [VEC_W-1:0] rep_o
);

    localparam logic [BIDX_W-1:0] ONE = BIDX_W'(1);

    logic [BYTES-1:0][7:0] src_bytes;
    logic [BIDX_W-1:0]     tup_mask;
    logic [BIDX_W-1:0]     in_elem_mask;

    assign tup_mask     = (ONE << tuple_i) - ONE;
    assign in_elem_mask = (ONE << esize_i) - ONE;

    // Source widened to the vector size; bytes beyond the source read zero.
    for (genvar s = 0; s < BYTES; s++) begin : g_src
        if (s < SRC_BYTES) begin : g_real
            assign src_bytes[s] = src_i[s*8 +: 8];
        end else begin : g_pad
            assign src_bytes[s] = 8'h00;
        end
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [BIDX_W-1:0] lane_d;
        logic [BIDX_W-1:0] pick_d;
        always_comb begin
            lane_d = BIDX_W'(b) >> esize_i;
            pick_d = ((lane_d & tup_mask) << esize_i)
                   | (BIDX_W'(b) & in_elem_mask);
        end
        assign rep_o[b*8 +: 8] = src_bytes[pick_d];
    end

endmodule

// File: rtl/vbcast_lane_ctrl.sv
module vbcast_lane_ctrl
    import vbcast_pkg::*;
(
    input  logic [MASK_W-1:0] mask_i,
    input  logic [1:0]        esize_i,
    input  logic [1:0]        vlen_i,
    input  logic              mask_en_i,
    input  logic              merge_i,
    output logic [BYTES-1:0]  byte_wr_o,
    output logic [BYTES-1:0]  byte_keep_o
);

    localparam int CNT_W = BIDX_W + 1;

    logic [1:0]       vl_eff;
    logic [CNT_W-1:0] act_bytes;

    assign vl_eff    = (vlen_i == VL_ALT) ? VL_512 : vlen_i;
    assign act_bytes = CNT_W'(16) << vl_eff;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BIDX_W-1:0] lane_idx;
        logic              active;
        logic              sel;
        always_comb begin
            lane_idx = BIDX_W'(b) >> esize_i;
            active   = CNT_W'(b) < act_bytes;
            sel      = !mask_en_i || mask_i[lane_idx];
            byte_wr_o[b]   = active && sel;
            byte_keep_o[b] = active && !sel && merge_i;
        end
    end

endmodule

// File: rtl/vbcast_unit.sv
module vbcast_unit
    import vbcast_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [255:0]      src_i,
    input  logic [511:0]      old_i,
    input  logic [63:0]       mask_i,
    input  logic [1:0]        esize_i,
    input  logic [1:0]        tuple_i,
    input  logic [1:0]        vlen_i,
    input  logic              mask_en_i,
    input  logic              merge_i,
    output logic [511:0]      result_o,
    output logic              done_o
);

    logic [VEC_W-1:0] rep_w;
    logic [BYTES-1:0] byte_wr_w;
    logic [BYTES-1:0] byte_keep_w;
    logic [VEC_W-1:0] next_vec;
    vb_state_t        st_d;
    vb_state_t        st_q;

    vbcast_replicate u_rep (
        .src_i   (src_i),
        .esize_i (esize_i),
        .tuple_i (tuple_i),
        .rep_o   (rep_w)
    );

    vbcast_lane_ctrl u_lane (
        .mask_i      (mask_i),
        .esize_i     (esize_i),
        .vlen_i      (vlen_i),
        .mask_en_i   (mask_en_i),
        .merge_i     (merge_i),
        .byte_wr_o   (byte_wr_w),
        .byte_keep_o (byte_keep_w)
    );

    for (genvar b = 0; b < BYTES; b++) begin : g_mix
        assign next_vec[b*8 +: 8] = byte_wr_w[b]   ? rep_w[b*8 +: 8] :
                                    byte_keep_w[b] ? old_i[b*8 +: 8] : 8'h00;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.result = next_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign done_o   = st_q.done;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && vlen_i == VL_128) |=> (result_o[511:128] == '0));

    // R8
    zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mask_en_i && !merge_i && mask_i == '0) |=> (result_o == '0));

    // R6
    nomask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mask_en_i && esize_i == ES_8)
        |=> (result_o[7:0] == $past(src_i[7:0])));

endmodule

// File: tb/tb_vbcast_unit.sv
`timescale 1ns/1ps
module tb_vbcast_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [255:0] src_i = '0;
    logic [511:0] old_i = '0;
    logic [63:0]  mask_i = '0;
    logic [1:0]   esize_i = '0;
    logic [1:0]   tuple_i = '0;
    logic [1:0]   vlen_i = '0;
    logic         mask_en_i = 1'b0;
    logic         merge_i = 1'b0;
    logic [511:0] result_o;
    logic         done_o;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vbcast_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
        .old_i(old_i), .mask_i(mask_i), .esize_i(esize_i), .tuple_i(tuple_i),
        .vlen_i(vlen_i), .mask_en_i(mask_en_i), .merge_i(merge_i),
        .result_o(result_o), .done_o(done_o)
    );

    function automatic logic [511:0] model(
        input logic [255:0] s, input logic [511:0] o, input logic [63:0] m,
        input int es, input int tc, input int vl, input bit men, input bit mrg);
        logic [511:0] r = '0;
        logic [511:0] se = {256'b0, s};
        logic [511:0] wmask;
        int w  = 8 << es;
        int vb = 128 << ((vl == 3) ? 2 : vl);
        int kl = vb / w;
        int t  = 1 << tc;
        wmask = (512'b1 << w) - 512'b1;
        for (int j = 0; j < kl; j++) begin
            logic [511:0] v;
            if (!men || m[j])
                v = (se >> ((j % t) * w)) & wmask;
            else if (mrg)
                v = (o >> (j * w)) & wmask;
            else
                v = '0;
            r = r | (v << (j * w));
        end
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [255:0] s, input logic [511:0] o, input logic [63:0] m,
                          input int es, input int tc, input int vl, input bit men, input bit mrg);
        @(negedge clk);
        src_i = s; old_i = o; mask_i = m;
        esize_i = 2'(es); tuple_i = 2'(tc); vlen_i = 2'(vl);
        mask_en_i = men; merge_i = mrg; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [255:0] s;
        logic [511:0] o;
        logic [63:0]  m;
        logic [511:0] exp;
        logic [511:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check_vec("R1 result", result_o, '0);
        check_bit("R1 done", done_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep all configurations (R3, R4, R5, R7, R8)
        for (int es = 0; es < 4; es++)
        for (int tc = 0; tc < 4; tc++)
        for (int vl = 0; vl < 4; vl++)
        for (int men = 0; men < 2; men++)
        for (int mrg = 0; mrg < 2; mrg++) begin
            string tag;
            s = rnd256();
            o = {rnd256(), rnd256()};
            m = {$urandom, $urandom};
            launch(s, o, m, es, tc, vl, men[0], mrg[0]);
            exp = model(s, o, m, es, tc, vl, men[0], mrg[0]);
            if (men == 0) tag = (tc == 0) ? "R4 sweep" : "R5 sweep";
            else          tag = (mrg != 0) ? "R7 sweep" : "R8 sweep";
            check_vec(tag, result_o, exp);
            check_bit("R2 done after start", done_o, 1'b1);
        end

        // R2: done drops, result holds
        held = result_o;
        @(negedge clk);
        check_bit("R2 done single", done_o, 1'b0);
        mask_i = '1; src_i = '1; old_i = '1;
        @(negedge clk);
        check_vec("R2 hold", result_o, held);

        // R3: length code 3 equals 512
        s = rnd256();
        launch(s, '0, '0, 1, 0, 3, 1'b0, 1'b0);
        check_vec("R3 alt length", result_o, {32{s[15:0]}});

        // R6: masking off ignores an all-zero mask
        s = rnd256();
        launch(s, '1, '0, 2, 0, 2, 1'b0, 1'b0);
        check_vec("R6 mask off", result_o, {16{s[31:0]}});

        // R9: all-ones old destination at 128 bits, merge
        s = rnd256();
        launch(s, '1, 64'h0, 0, 0, 0, 1'b1, 1'b1);
        check_vec("R9 upper clear", result_o, {384'b0, {128{1'b1}}});

        // R10: mask bits only above lane count (64-bit, 128 -> 2 lanes)
        s = rnd256();
        o = {rnd256(), rnd256()};
        launch(s, o, 64'hFFFF_FFFF_FFFF_FFFC, 3, 0, 0, 1'b1, 1'b0);
        check_vec("R10 high mask ignored", result_o, '0);
        launch(s, o, 64'hFFFF_FFFF_FFFF_FFFD, 3, 0, 0, 1'b1, 1'b1);
        check_vec("R10 lane0 only", result_o, {384'b0, o[127:64], s[63:0]});

        // R11: 128-bit block copy into 256 bits
        s = rnd256();
        launch(s, '1, '0, 2, 2, 1, 1'b0, 1'b0);
        check_vec("R11 block copy", result_o, {256'b0, s[127:0], s[127:0]});

        // R5: 64-bit tuple of 8 reads zero beyond source
        s = rnd256();
        launch(s, '1, '0, 3, 3, 2, 1'b0, 1'b0);
        check_vec("R5 tuple8 pad", result_o, {256'b0, s});

        finish_run();
    end

endmodule